// File: doc/BRIEF.md
# Sigma-Delta Converter Bring-Up Sequencer

This block runs on the host side of a parallel-bus sigma-delta converter and uses the converter's master clock as its own clock. After the host reset is released, it walks the converter through its power-up sequence. It holds the converter in reset and then waits out the post-reset settling time. Next it writes the second control register (power-up bits and the clock-divide select) and then the first control register (both filter-bypass bits set, decimation field cleared), which places the converter in raw modulator output mode. It then waits after the final chip-select release and pulses the active-low sync line.

While it sequences, the block counts master-clock cycles from the converter's reset release to its sync release. The least significant bit of that count is the parity flag. When the clock-divide select is 0 and the count is odd, modulator words are sampled on a falling clock edge while data-ready is low. In every other case they are sampled on the rising edge at which data-ready is first seen low. Each captured word is presented with a one-cycle valid strobe. Once sync is released the block raises `seq_done` and makes no further bus access.

The FSM states are: ST_RESET (converter reset low, configuration inputs latched), ST_POST_RST (settle wait), ST_W2_ADDR, ST_W2_DATA, ST_GAP (chip select high between writes), ST_W1_ADDR, ST_W1_DATA, ST_SETTLE (wait after the final chip-select rise), ST_SYNC (sync low) and ST_RUN (done, capturing). Each state advances to the next in that order when its wait counter reaches the state's limit. The limit is RST_CYC, PRE_WR_CYC, SETTLE_CYC plus `settle_pad`, SYNC_CYC, or 1 cycle for the write and gap states. ST_RUN holds until reset.

Top module: `mod_adc_bringup`

## Requirements
- R1: While `rst_n` is low, and for RST_CYC (default 2) samples counting the one taken at release, `adc_rst_n` is low, `adc_cs_n` and `adc_sync_n` are high, and `seq_done` and `word_valid` are 0. Asserting `rst_n` mid-run returns these outputs at once.
- R2: After `adc_rst_n` rises, `adc_cs_n` stays high for PRE_WR_CYC (default 3, at least 2) cycles.
- R3: The first write is one cycle of address 0x0002 followed by one cycle of data. The data is 0x0002, with bit 4 set to the latched clock-divide select, giving 0x0002 or 0x0012. In both cycles `adc_cs_n`=0, `adc_rw_n`=0 and `adc_bus_oe`=1.
- R4: `adc_cs_n` returns high for exactly one cycle between the two writes.
- R5: The second write is address 0x0001 followed by data 0x0028, which has bypass bits 3 and 5 set and the decimation field in bits 2:0 equal to zero.
- R6: After the second write, `adc_cs_n` stays high for SETTLE_CYC + `settle_pad` cycles (default 6 + pad) before `adc_sync_n` falls.
- R7: `adc_sync_n` stays low for SYNC_CYC (default 4) cycles. `seq_done` rises in the same cycle that `adc_sync_n` rises, and it stays high.
- R8: `r2s_parity` is bit 0 of the number of cycles `adc_rst_n` is high before `adc_sync_n` rises. With the defaults that count is 18 + `settle_pad`. The flag is stable once `seq_done` is high.
- R9: When the clock-divide select is 1 or the parity is even, `adc_bus_in` is captured at the rising edge at which `adc_drdy_n` is first seen low. `word_valid` is high for the one cycle after that edge, with the word on `word_out`.
- R10: When the clock-divide select is 0 and the parity is odd, `adc_bus_in` is captured at the first falling edge with `adc_drdy_n` low. `word_valid` is high for the one cycle after the next rising edge.
- R11: `adc_drdy_n` activity before `seq_done` produces no `word_valid`. Each low pulse of `adc_drdy_n` yields exactly one `word_valid` cycle, however long the pulse lasts.
- R12: Once `seq_done` is high, `adc_cs_n` stays high and `adc_bus_oe` stays 0, so only the two control registers are ever written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter master clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| cdiv_sel | input | 1 | Clock-divide select written into the second register; latched in ST_RESET |
| settle_pad | input | 4 | Extra cycles added to the post-write wait; latched in ST_RESET |
| adc_rst_n | output | 1 | Converter reset, active low |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rw_n | output | 1 | Read/write strobe, low for write |
| adc_sync_n | output | 1 | Converter sync, active low |
| adc_bus_out | output | 16 | Address/data driven during writes |
| adc_bus_oe | output | 1 | Enable for the bus drivers |
| adc_bus_in | input | 16 | Modulator words from the converter |
| adc_drdy_n | input | 1 | Converter data-ready, active low |
| seq_done | output | 1 | Bring-up finished, capture armed |
| r2s_parity | output | 1 | Parity of the reset-to-sync cycle count |
| word_out | output | 16 | Last captured modulator word |
| word_valid | output | 1 | One-cycle strobe for `word_out` |

## Verification
The bench traces every output cycle by cycle from reset release to the run state, for several settle paddings and both clock-divide settings. An off-by-one wait, a merged write gap or a wrong register word therefore shows up as a miscompare at one exact cycle. Capture is tested by changing the bus between the rising edge that first sees data-ready low and the following falling edge. A design that uses the wrong edge for a given parity then returns the other word, or raises valid one cycle early or late. Data-ready pulses are also applied during the bring-up sequence, and data-ready is held low for several cycles after done. A design that arms capture too early, or that captures on level rather than on the edge, produces extra valid strobes.

// File: rtl/mab_pkg.sv
`timescale 1ns/1ps
package mab_pkg;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_POST_RST,
        ST_W2_ADDR,
        ST_W2_DATA,
        ST_GAP,
        ST_W1_ADDR,
        ST_W1_DATA,
        ST_SETTLE,
        ST_SYNC,
        ST_RUN
    } seq_state_e;

endpackage

// File: rtl/mab_seq_fsm.sv
`timescale 1ns/1ps
module mab_seq_fsm
    import mab_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int PAD_W      = 4,
    parameter int CNT_W      = 8,
    parameter int RST_CYC    = 2,
    parameter int PRE_WR_CYC = 3,
    parameter int SETTLE_CYC = 6,
    parameter int SYNC_CYC   = 4,
    parameter logic [DATA_W-1:0] ADDR_CR1 = 16'h0001,
    parameter logic [DATA_W-1:0] ADDR_CR2 = 16'h0002,
    parameter logic [DATA_W-1:0] CR2_BASE = 16'h0002,
    parameter int CDIV_BIT   = 4,
    parameter int BYP_A_BIT  = 3,
    parameter int BYP_B_BIT  = 5,
    parameter int DEC_LSB    = 0,
    parameter int DEC_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cdiv_sel,
    input  logic [PAD_W-1:0]  settle_pad,
    output logic              adc_rst_n,
    output logic              adc_cs_n,
    output logic              adc_rw_n,
    output logic              adc_sync_n,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              done,
    output logic              cdiv_q,
    output logic              count_en,
    output logic              count_clr
);

    localparam logic [DATA_W-1:0] BYP_BITS =
        (DATA_W'(1) << BYP_A_BIT) | (DATA_W'(1) << BYP_B_BIT);
    localparam logic [DATA_W-1:0] DEC_MASK =
        ((DATA_W'(1) << DEC_W) - DATA_W'(1)) << DEC_LSB;
    localparam logic [DATA_W-1:0] CR1_WORD = BYP_BITS & ~DEC_MASK;

    seq_state_e          state_q, state_d;
    logic [CNT_W-1:0]    wait_q;
    logic [CNT_W-1:0]    limit;
    logic [PAD_W-1:0]    pad_q;
    logic                last_cyc;
    logic [DATA_W-1:0]   cr2_word;

    always_comb begin
        cr2_word           = CR2_BASE;
        cr2_word[CDIV_BIT] = cdiv_q;
    end

    // Dwell length of the current state
    always_comb begin
        unique case (state_q)
            ST_RESET:    limit = CNT_W'(RST_CYC);
            ST_POST_RST: limit = CNT_W'(PRE_WR_CYC);
            ST_SETTLE:   limit = CNT_W'(SETTLE_CYC) + CNT_W'(pad_q);
            ST_SYNC:     limit = CNT_W'(SYNC_CYC);
            default:     limit = CNT_W'(1);
        endcase
    end

    assign last_cyc = (wait_q == limit - CNT_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:    if (last_cyc) state_d = ST_POST_RST;
            ST_POST_RST: if (last_cyc) state_d = ST_W2_ADDR;
            ST_W2_ADDR:  if (last_cyc) state_d = ST_W2_DATA;
            ST_W2_DATA:  if (last_cyc) state_d = ST_GAP;
            ST_GAP:      if (last_cyc) state_d = ST_W1_ADDR;
            ST_W1_ADDR:  if (last_cyc) state_d = ST_W1_DATA;
            ST_W1_DATA:  if (last_cyc) state_d = ST_SETTLE;
            ST_SETTLE:   if (last_cyc) state_d = ST_SYNC;
            ST_SYNC:     if (last_cyc) state_d = ST_RUN;
            ST_RUN:      state_d = ST_RUN;
            default:     state_d = ST_RESET;
        endcase
    end

    // State register, dwell counter and configuration latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
            wait_q  <= '0;
            cdiv_q  <= 1'b0;
            pad_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                wait_q <= '0;
            end else if (state_q != ST_RUN) begin
                wait_q <= wait_q + CNT_W'(1);
            end
            if (state_q == ST_RESET) begin
                cdiv_q <= cdiv_sel;
                pad_q  <= settle_pad;
            end
        end
    end

    // Moore outputs
    always_comb begin
        adc_rst_n  = 1'b1;
        adc_cs_n   = 1'b1;
        adc_rw_n   = 1'b1;
        adc_sync_n = 1'b1;
        bus_out    = '0;
        bus_oe     = 1'b0;
        done       = 1'b0;
        count_en   = 1'b0;
        count_clr  = 1'b0;
        unique case (state_q)
            ST_RESET: begin
                adc_rst_n = 1'b0;
                count_clr = 1'b1;
            end
            ST_POST_RST, ST_GAP, ST_SETTLE: begin
                count_en = 1'b1;
            end
            ST_W2_ADDR, ST_W2_DATA, ST_W1_ADDR, ST_W1_DATA: begin
                count_en = 1'b1;
                adc_cs_n = 1'b0;
                adc_rw_n = 1'b0;
                bus_oe   = 1'b1;
                unique case (state_q)
                    ST_W2_ADDR: bus_out = ADDR_CR2;
                    ST_W2_DATA: bus_out = cr2_word;
                    ST_W1_ADDR: bus_out = ADDR_CR1;
                    default:    bus_out = CR1_WORD;
                endcase
            end
            ST_SYNC: begin
                count_en   = 1'b1;
                adc_sync_n = 1'b0;
            end
            ST_RUN: begin
                done = 1'b1;
            end
            default: begin
                adc_rst_n = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mab_r2s_counter.sv
`timescale 1ns/1ps
module mab_r2s_counter #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic parity
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign parity = cnt_q[0];

endmodule

// File: rtl/mab_capture.sv
`timescale 1ns/1ps
module mab_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              odd_mode,
    input  logic              drdy_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] word_out,
    output logic              word_valid
);

    logic              drdy_prev;
    logic [DATA_W-1:0] neg_word;
    logic              neg_taken;
    logic              neg_taken_d;
    logic              rise_hit;
    logic              fall_hit;

    // Falling-edge sampler for the odd-parity case
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            neg_word  <= '0;
            neg_taken <= 1'b0;
        end else if (drdy_n) begin
            neg_taken <= 1'b0;
        end else if (arm && odd_mode && !neg_taken) begin
            neg_word  <= data_in;
            neg_taken <= 1'b1;
        end
    end

    assign rise_hit = arm && !odd_mode && !drdy_n && drdy_prev;
    assign fall_hit = arm && odd_mode && neg_taken && !neg_taken_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drdy_prev   <= 1'b1;
            neg_taken_d <= 1'b0;
            word_out    <= '0;
            word_valid  <= 1'b0;
        end else begin
            drdy_prev   <= drdy_n;
            neg_taken_d <= neg_taken;
            word_valid  <= rise_hit || fall_hit;
            if (rise_hit) begin
                word_out <= data_in;
            end else if (fall_hit) begin
                word_out <= neg_word;
            end
        end
    end

endmodule

// File: rtl/mod_adc_bringup.sv
`timescale 1ns/1ps
module mod_adc_bringup #(
    parameter int DATA_W     = 16,
    parameter int PAD_W      = 4,
    parameter int RST_CYC    = 2,
    parameter int PRE_WR_CYC = 3,
    parameter int SETTLE_CYC = 6,
    parameter int SYNC_CYC   = 4,
    parameter logic [DATA_W-1:0] ADDR_CR1 = 16'h0001,
    parameter logic [DATA_W-1:0] ADDR_CR2 = 16'h0002,
    parameter logic [DATA_W-1:0] CR2_BASE = 16'h0002,
    parameter int CDIV_BIT   = 4,
    parameter int BYP_A_BIT  = 3,
    parameter int BYP_B_BIT  = 5,
    parameter int DEC_LSB    = 0,
    parameter int DEC_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cdiv_sel,
    input  logic [PAD_W-1:0]  settle_pad,
    output logic              adc_rst_n,
    output logic              adc_cs_n,
    output logic              adc_rw_n,
    output logic              adc_sync_n,
    output logic [DATA_W-1:0] adc_bus_out,
    output logic              adc_bus_oe,
    input  logic [DATA_W-1:0] adc_bus_in,
    input  logic              adc_drdy_n,
    output logic              seq_done,
    output logic              r2s_parity,
    output logic [DATA_W-1:0] word_out,
    output logic              word_valid
);

    localparam int CNT_W = $clog2(RST_CYC + PRE_WR_CYC + SETTLE_CYC + SYNC_CYC
                                  + (1 << PAD_W) + 8) + 1;

    logic cdiv_q;
    logic count_en;
    logic count_clr;
    logic odd_mode;

    mab_seq_fsm #(
        .DATA_W(DATA_W), .PAD_W(PAD_W), .CNT_W(CNT_W),
        .RST_CYC(RST_CYC), .PRE_WR_CYC(PRE_WR_CYC),
        .SETTLE_CYC(SETTLE_CYC), .SYNC_CYC(SYNC_CYC),
        .ADDR_CR1(ADDR_CR1), .ADDR_CR2(ADDR_CR2), .CR2_BASE(CR2_BASE),
        .CDIV_BIT(CDIV_BIT), .BYP_A_BIT(BYP_A_BIT), .BYP_B_BIT(BYP_B_BIT),
        .DEC_LSB(DEC_LSB), .DEC_W(DEC_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cdiv_sel   (cdiv_sel),
        .settle_pad (settle_pad),
        .adc_rst_n  (adc_rst_n),
        .adc_cs_n   (adc_cs_n),
        .adc_rw_n   (adc_rw_n),
        .adc_sync_n (adc_sync_n),
        .bus_out    (adc_bus_out),
        .bus_oe     (adc_bus_oe),
        .done       (seq_done),
        .cdiv_q     (cdiv_q),
        .count_en   (count_en),
        .count_clr  (count_clr)
    );

    mab_r2s_counter #(.CNT_W(CNT_W)) u_r2s (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (count_clr),
        .en     (count_en),
        .parity (r2s_parity)
    );

    assign odd_mode = r2s_parity && !cdiv_q;

    mab_capture #(.DATA_W(DATA_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (seq_done),
        .odd_mode   (odd_mode),
        .drdy_n     (adc_drdy_n),
        .data_in    (adc_bus_in),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

endmodule

// File: rtl/mod_adc_bringup_chk.sv
`timescale 1ns/1ps
module mod_adc_bringup_chk #(
    parameter int DATA_W = 16,
    parameter int PAD_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cdiv_sel,
    input logic [PAD_W-1:0]  settle_pad,
    input logic              adc_rst_n,
    input logic              adc_cs_n,
    input logic              adc_rw_n,
    input logic              adc_sync_n,
    input logic [DATA_W-1:0] adc_bus_out,
    input logic              adc_bus_oe,
    input logic [DATA_W-1:0] adc_bus_in,
    input logic              adc_drdy_n,
    input logic              seq_done,
    input logic              r2s_parity,
    input logic [DATA_W-1:0] word_out,
    input logic              word_valid
);

    // R1: no access or sync while the converter is held in reset
    p_quiet_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rst_n |-> (adc_cs_n && adc_sync_n));

    // R3: a selected cycle is always a driven write
    p_write_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_cs_n |-> (!adc_rw_n && adc_bus_oe));

    // R7: done is sticky
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> seq_done);

    // R7: done rises together with the sync release
    p_done_on_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_done) |-> (adc_sync_n && !$past(adc_sync_n)));

    // R8: parity frozen after done
    p_parity_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && $past(seq_done)) |-> $stable(r2s_parity));

    // R9: valid is a single-cycle strobe
    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R11: no word before bring-up completes
    p_no_early_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_done |-> !word_valid);

    // R12: bus stays released once running
    p_bus_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (adc_cs_n && !adc_bus_oe));

endmodule

bind mod_adc_bringup mod_adc_bringup_chk #(.DATA_W(DATA_W), .PAD_W(PAD_W)) u_chk (.*);

// File: tb/mod_adc_bringup_bench.sv
`timescale 1ns/1ps
module mod_adc_bringup_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cdiv_sel = 1'b0;
    logic [3:0]  settle_pad = '0;
    logic        adc_rst_n, adc_cs_n, adc_rw_n, adc_sync_n, adc_bus_oe;
    logic [15:0] adc_bus_out;
    logic [15:0] adc_bus_in = '0;
    logic        adc_drdy_n = 1'b1;
    logic        seq_done, r2s_parity, word_valid;
    logic [15:0] word_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // {cdiv[6], pad[5:2], expected parity[1], expected falling-edge capture[0]}
    localparam logic [6:0] VEC [6] = '{
        7'b0_0000_0_0,
        7'b0_0001_1_1,
        7'b1_0001_1_0,
        7'b1_0000_0_0,
        7'b0_0011_1_1,
        7'b0_0010_0_0
    };

    always #2 clk = ~clk;

    mod_adc_bringup u_mod_adc_bringup (
        .clk(clk), .rst_n(rst_n), .cdiv_sel(cdiv_sel), .settle_pad(settle_pad),
        .adc_rst_n(adc_rst_n), .adc_cs_n(adc_cs_n), .adc_rw_n(adc_rw_n),
        .adc_sync_n(adc_sync_n), .adc_bus_out(adc_bus_out), .adc_bus_oe(adc_bus_oe),
        .adc_bus_in(adc_bus_in), .adc_drdy_n(adc_drdy_n), .seq_done(seq_done),
        .r2s_parity(r2s_parity), .word_out(word_out), .word_valid(word_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // {rst_n, cs_n, rw_n, sync_n, oe, done, bus}
    function automatic logic [21:0] exp_snap(int k, int pad, bit cd);
        logic [5:0]  c = 6'b111100;
        logic [15:0] b = 16'h0000;
        if (k < 2)              c = 6'b011100;
        else if (k < 5)         c = 6'b111100;
        else if (k == 5)  begin c = 6'b100110; b = 16'h0002; end
        else if (k == 6)  begin c = 6'b100110; b = cd ? 16'h0012 : 16'h0002; end
        else if (k == 7)        c = 6'b111100;
        else if (k == 8)  begin c = 6'b100110; b = 16'h0001; end
        else if (k == 9)  begin c = 6'b100110; b = 16'h0028; end
        else if (k < 16 + pad)  c = 6'b111100;
        else if (k < 20 + pad)  c = 6'b111000;
        else                    c = 6'b111101;
        return {c, b};
    endfunction

    function automatic string tag(int k, int pad);
        if (k < 2)              return "R1 reset";
        else if (k < 5)         return "R2 post-reset wait";
        else if (k < 7)         return "R3 write reg2";
        else if (k == 7)        return "R4 gap";
        else if (k < 10)        return "R5 write reg1";
        else if (k < 16 + pad)  return "R6 settle";
        else if (k < 20 + pad)  return "R7 sync low";
        else                    return "R7 R12 run";
    endfunction

    task automatic start_run(input bit cd, input logic [3:0] pad);
        rst_n      = 1'b0;
        cdiv_sel   = cd;
        settle_pad = pad;
        adc_drdy_n = 1'b1;
        adc_bus_in = '0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic trace_run(input bit cd, input int pad);
        for (int k = 0; k <= 24 + pad; k++) begin
            logic [21:0] act;
            logic [21:0] exp;
            act = {adc_rst_n, adc_cs_n, adc_rw_n, adc_sync_n, adc_bus_oe, seq_done,
                   adc_bus_out & {16{adc_bus_oe}}};
            exp = exp_snap(k, pad, cd);
            chk(act == exp, tag(k, pad), {10'd0, act}, {10'd0, exp});
            if (k < 24 + pad) tick();
        end
    endtask

    task automatic capture_test(input bit odd, input logic [15:0] wa, input logic [15:0] wb);
        @(negedge clk);
        #1;
        adc_drdy_n = 1'b0;
        adc_bus_in = wa;
        tick();
        if (!odd) begin
            chk(word_valid === 1'b1, "R9 rising-edge valid", {31'd0, word_valid}, 32'd1);
            chk(word_out === wa, "R9 rising-edge word", {16'd0, word_out}, {16'd0, wa});
        end else begin
            chk(word_valid === 1'b0, "R10 no early valid", {31'd0, word_valid}, 32'd0);
        end
        adc_bus_in = wb;
        tick();
        if (odd) begin
            chk(word_valid === 1'b1, "R10 falling-edge valid", {31'd0, word_valid}, 32'd1);
            chk(word_out === wb, "R10 falling-edge word", {16'd0, word_out}, {16'd0, wb});
        end else begin
            chk(word_valid === 1'b0, "R9 single strobe", {31'd0, word_valid}, 32'd0);
        end
        tick();
        chk(word_valid === 1'b0, "R11 one strobe per pulse", {31'd0, word_valid}, 32'd0);
        chk(adc_cs_n === 1'b1 && adc_bus_oe === 1'b0, "R12 bus idle",
            {30'd0, adc_cs_n, adc_bus_oe}, 32'd2);
        adc_drdy_n = 1'b1;
        tick();
        chk(word_valid === 1'b0, "R11 quiet after pulse", {31'd0, word_valid}, 32'd0);
    endtask

    initial begin
        for (int v = 0; v < 6; v++) begin
            logic       cd;
            logic [3:0] pd;
            logic       ep;
            logic       eo;
            cd = VEC[v][6];
            pd = VEC[v][5:2];
            ep = VEC[v][1];
            eo = VEC[v][0];
            start_run(cd, pd);
            trace_run(cd, int'(pd));
            chk(r2s_parity === ep, "R8 parity", {31'd0, r2s_parity}, {31'd0, ep});
            capture_test(eo, 16'hA500 + 16'(v), 16'h5A00 + 16'(v));
            capture_test(eo, 16'h1230 + 16'(v), 16'hFED0 + 16'(v));
        end

        // R11: data-ready pulses during bring-up are ignored
        start_run(1'b0, 4'd0);
        for (int k = 0; k < 19; k++) begin
            adc_drdy_n = (k % 3 == 2);
            adc_bus_in = 16'h0F00 + 16'(k);
            chk(word_valid === 1'b0, "R11 ignored before done", {31'd0, word_valid}, 32'd0);
            tick();
        end
        adc_drdy_n = 1'b1;
        repeat (3) tick();
        chk(seq_done === 1'b1, "R7 done after sequence", {31'd0, seq_done}, 32'd1);
        chk(word_valid === 1'b0, "R11 no stale word", {31'd0, word_valid}, 32'd0);

        // R11: long low pulse gives one strobe only (even mode)
        @(negedge clk);
        #1;
        adc_drdy_n = 1'b0;
        adc_bus_in = 16'hBEEF;
        tick();
        chk(word_valid === 1'b1 && word_out === 16'hBEEF, "R11 long pulse first",
            {15'd0, word_valid, word_out}, {15'd0, 1'b1, 16'hBEEF});
        for (int k = 0; k < 5; k++) begin
            tick();
            chk(word_valid === 1'b0, "R11 long pulse hold", {31'd0, word_valid}, 32'd0);
        end
        adc_drdy_n = 1'b1;

        // R1: mid-run reset returns the reset outputs immediately
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        #0.5;
        chk(adc_rst_n === 1'b0 && seq_done === 1'b0 && adc_cs_n === 1'b1
            && adc_sync_n === 1'b1 && word_valid === 1'b0, "R1 mid-run reset",
            {27'd0, adc_rst_n, seq_done, adc_cs_n, adc_sync_n, word_valid}, 32'h06);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule